// File: doc/BRIEF.md
# DMA Interrupt Register Block

This block collects interrupt events from a DMA-style peripheral and presents them to software through four word registers on a simple register bus. Each event input that pulses high latches a pending bit. Software acknowledges a pending bit by writing a one to it. A per-source mask decides which pending bits reach the single interrupt line.

The mask is never written directly. Software changes it through two command addresses. One command unmasks the selected sources and the other masks them. Each command touches only the bits written as one, so two software threads can change different mask bits without a read-modify-write race. The command addresses store nothing and read back as zero.

Reads are combinational from the address. A write takes effect at the rising clock edge where the write strobe is high. An event is recorded at the rising edge where its input is high, and the interrupt line follows on the registered state after that edge.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads all ones and `irq_o` is low.
- R2: An `event_i` bit high at a clock edge sets the matching pending bit, whether or not that source is masked.
- R3: Writing to the pending register (address 0) clears every pending bit written as 1. Bits written as 0 keep their value.
- R4: If an event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: Writing to the unmask command (address 2) clears the mask bits written as 1 and leaves the other mask bits unchanged.
- R6: Writing to the mask command (address 3) sets the mask bits written as 1 and leaves the other mask bits unchanged. It does not change any pending bit.
- R7: Reads of addresses 2 and 3 return 0. A write to the mask register address (1) has no effect.
- R8: `irq_o` is high exactly when some pending bit is set and its mask bit is clear. It rises as soon as a masked pending source is unmasked.
- R9: A write to any address above 3 changes no state, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr_i | input | ADDR_W (4) | Word address of the register access |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_SRC (8) | Write data |
| reg_rdata_o | output | NUM_SRC (8) | Read data for `reg_addr_i` |
| event_i | input | NUM_SRC (8) | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request |

## Verification
A pending bit that is lost or cleared when it should not be shows up in two places. Its value is wrong on the next read of address 0, and `irq_o` is wrong in the first cycle after the edge, provided the source is unmasked. A corrupted mask bit shows up on the next read of address 1. For a pending source it also moves `irq_o` right away. For this reason the bench compares `irq_o` on every read, in addition to the read data. The ordering cases are a clear that collides with an event, a mask command issued after an unmask command, and a write to the mask register address or an unmapped address. Each of these is followed at once by reads, so any stray state change is seen within one cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Word addresses; software depends on these.
  localparam int unsigned ADR_PEND   = 0;
  localparam int unsigned ADR_MASK   = 1;
  localparam int unsigned ADR_UNMASK = 2;
  localparam int unsigned ADR_DOMASK = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_UNMASK,
    SEL_DOMASK
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] clr_bits_o,
  output logic [NUM_SRC-1:0] unmask_bits_o,
  output logic [NUM_SRC-1:0] domask_bits_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  reg_sel_e sel;

  always_comb begin
    case (addr_i)
      ADDR_W'(ADR_PEND):   sel = SEL_PEND;
      ADDR_W'(ADR_MASK):   sel = SEL_MASK;
      ADDR_W'(ADR_UNMASK): sel = SEL_UNMASK;
      ADDR_W'(ADR_DOMASK): sel = SEL_DOMASK;
      default:             sel = SEL_NONE;
    endcase
  end

  // Write commands: data gated by strobe and selected address.
  always_comb begin
    clr_bits_o    = '0;
    unmask_bits_o = '0;
    domask_bits_o = '0;
    if (we_i) begin
      case (sel)
        SEL_PEND:   clr_bits_o    = wdata_i;
        SEL_UNMASK: unmask_bits_o = wdata_i;
        SEL_DOMASK: domask_bits_o = wdata_i;
        default:    ;
      endcase
    end
  end

  // Command addresses read as zero.
  always_comb begin
    case (sel)
      SEL_PEND: rdata_o = pend_i;
      SEL_MASK: rdata_o = mask_i;
      default:  rdata_o = '0;
    endcase
  end

  // R9: at most one command vector is active in any cycle.
  a_r9_one_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|clr_bits_o, |unmask_bits_o, |domask_bits_o}));
endmodule

// File: rtl/dma_irq_pending.sv
module dma_irq_pending #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic               pend_en;

  // The event term is ORed in last, so it wins over a clear (R4).
  always_comb begin
    pend_en = (|event_i) | (|clr_bits_i);
    pend_d  = (pend_q & ~clr_bits_i) | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R2 and R4: every event seen at an edge is pending afterwards.
  a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((pend_q & $past(event_i)) == $past(event_i)));

  // R3: a pending bit falls only where a one was written to clear it.
  a_r3_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_bits_i)) == '0));
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] unmask_bits_i,
  input  logic [NUM_SRC-1:0] domask_bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  // The masking term is ORed in last, so it wins if both are set in one cycle.
  always_comb begin
    mask_en = (|unmask_bits_i) | (|domask_bits_i);
    mask_d  = (mask_q & ~unmask_bits_i) | domask_bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r5_unmask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|unmask_bits_i) && !(|domask_bits_i)) |=> ((mask_q & $past(unmask_bits_i)) == '0));

  a_r6_domask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|domask_bits_i) |=> ((mask_q & $past(domask_bits_i)) == $past(domask_bits_i)));

  // R7: without a command, the mask holds.
  a_r7_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|unmask_bits_i) && !(|domask_bits_i)) |=> $stable(mask_q));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend, mask, clr_bits, unmask_bits, domask_bits;
  logic [NUM_SRC-1:0] live;

  dma_irq_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (reg_addr_i),
    .we_i          (reg_we_i),
    .wdata_i       (reg_wdata_i),
    .pend_i        (pend),
    .mask_i        (mask),
    .clr_bits_o    (clr_bits),
    .unmask_bits_o (unmask_bits),
    .domask_bits_o (domask_bits),
    .rdata_o       (reg_rdata_o)
  );

  dma_irq_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .clr_bits_i (clr_bits),
    .pend_o     (pend)
  );

  dma_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .unmask_bits_i (unmask_bits),
    .domask_bits_i (domask_bits),
    .mask_o        (mask)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
    assign live[i] = pend[i] & ~mask[i];
  end

  assign irq_o = |live;

  // R8: the line can rise only after an event or an unmask command.
  a_r8_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|event_i) || $past(|unmask_bits)));

  // R6: a mask command never drops a pending bit.
  a_r6_domask_keeps_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|domask_bits) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/dma_irq_regs_tb.sv
`timescale 1ns/1ps
module dma_irq_regs_tb;
  localparam int unsigned N = 8;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  evt = '0;
  logic          irq;

  always #2.5 clk = ~clk;

  dma_irq_regs #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(evt), .irq_o(irq)
  );

  typedef struct {
    logic [N-1:0] data;
    logic         irq;
    string        tag;
  } item_t;

  item_t  sbq[$];
  int     checks = 0;
  int     errors = 0;
  logic [N-1:0] m_pend, m_mask;

  function automatic logic m_irq();
    return |(m_pend & ~m_mask);
  endfunction

  // Driver: one bus cycle per task, all inputs driven at the falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d, input logic [N-1:0] e);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d; evt = e;
    case (a)
      4'd0: m_pend = (m_pend & ~d) | e;
      4'd2: begin m_mask = m_mask & ~d; m_pend = m_pend | e; end
      4'd3: begin m_mask = m_mask | d;  m_pend = m_pend | e; end
      default: m_pend = m_pend | e;
    endcase
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = e;
    m_pend = m_pend | e;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0; addr = a;
    it.data = exp; it.irq = m_irq(); it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares one queued item per cycle, 1 ns after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (rdata !== it.data) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", it.tag, rdata, it.data);
        end
        checks++;
        if (irq !== it.irq) begin
          errors++;
          $display("FAIL %s irq actual %b expected %b", it.tag, irq, it.irq);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pend = '0; m_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(4'd0, m_pend, "R1 pending reset");
    rd(4'd1, m_mask, "R1 mask reset");
    rd(4'd2, 8'h00, "R7 unmask reads zero");
    rd(4'd3, 8'h00, "R7 domask reads zero");

    pulse(8'h05);
    rd(4'd0, m_pend, "R2 event while masked");
    wr(4'd2, 8'h01, 8'h00);
    rd(4'd1, m_mask, "R5 unmask bit0");
    rd(4'd2, 8'h00, "R7 unmask still zero");
    rd(4'd0, m_pend, "R8 unmasked pending raises irq");

    wr(4'd0, 8'h00, 8'h00);
    rd(4'd0, m_pend, "R3 write zero keeps");
    wr(4'd0, 8'h04, 8'h00);
    rd(4'd0, m_pend, "R3 write one clears");

    wr(4'd3, 8'h01, 8'h00);
    rd(4'd1, m_mask, "R6 domask bit0");
    rd(4'd0, m_pend, "R6 pending untouched by domask");

    wr(4'd2, 8'h81, 8'h00);
    wr(4'd3, 8'h80, 8'h00);
    rd(4'd1, m_mask, "R6 later command decides");
    rd(4'd0, m_pend, "R8 irq after unmask");

    wr(4'd0, 8'h03, 8'h03);
    rd(4'd0, m_pend, "R4 event wins over clear");

    wr(4'd1, 8'h00, 8'h00);
    rd(4'd1, m_mask, "R7 mask address write ignored");

    wr(4'd7, 8'hFF, 8'h00);
    rd(4'd0, m_pend, "R9 unmapped write pending");
    rd(4'd1, m_mask, "R9 unmapped write mask");
    rd(4'd7, 8'h00, "R9 unmapped read zero");
    wr(4'd15, 8'hFF, 8'h00);
    rd(4'd1, m_mask, "R9 top address write mask");

    wr(4'd0, 8'hFF, 8'h00);
    rd(4'd0, m_pend, "R3 clear all");

    wr(4'd2, 8'hFF, 8'h00);
    for (int i = 0; i < N; i++) begin
      pulse(8'(1 << i));
      rd(4'd0, m_pend, "R8 walking source");
      wr(4'd0, 8'(1 << i), 8'h00);
      rd(4'd0, m_pend, "R3 walking clear");
    end

    wr(4'd3, 8'hFF, 8'h00);
    pulse(8'h40);
    rd(4'd0, m_pend, "R2 masked source quiet");
    wr(4'd2, 8'h40, 8'h00);
    rd(4'd1, m_mask, "R8 unmask rises irq");

    rd(4'd0, m_pend, "final");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule